// File: doc/BRIEF.md
# Paged Address Translator with Associative Cache

This block turns 16-bit logical addresses from a single running process into physical addresses. The upper six bits of a logical address select a page and the lower ten bits are a byte offset into a 1 KB page. An eight-entry fully associative cache of recent page-to-frame pairs is searched first, with every entry compared at once. If the cache has no match, the block reads one page-table entry from memory, checks it, caches it and returns the result. It may instead return a fault code.

Software programs two context registers: the physical byte address where the current page table starts and the number of entries that table holds. Each table entry is 16 bits wide. Bit 15 marks the page as present and the low bits hold the frame number. When software switches to another process it pulses `flush`, which empties the cache. If a flush arrives while a table read is outstanding, that read's result is still returned but is never cached.

The translation request and response ports both use valid/ready. A request is accepted only while the block is idle, so only one translation is in flight. A response stays valid, with its payload unchanged, until the consumer raises `rsp_ready`. The block holds the memory read request, with its address unchanged, until `mem_req_ready` is high. Read data comes back later as a single-cycle `mem_rsp_valid` pulse, which the block always accepts.

Top module: `paging_mmu`

## Requirements
- R1: A successful response has `rsp_fault` = 0 and `rsp_paddr` = {frame number, the request's unchanged 10-bit offset}, where the upper 6 bits of `req_laddr` are the page number.
- R2: A request whose page is cached completes without issuing any memory read.
- R3: A request whose page is not cached issues exactly one memory read, at address base + 2 × page. Bit 15 of the returned entry is the present flag and bits 5:0 are the frame. A present entry is then cached, so an immediate repeat of that page makes no read.
- R4: A page number greater than or equal to the length register gives `rsp_fault` = 1 and `rsp_paddr` = 0 with no memory read, even when the page is cached. Page length−1 translates normally.
- R5: A table entry with bit 15 clear gives `rsp_fault` = 2 and `rsp_paddr` = 0. It is never cached, so repeating the request reads memory again.
- R6: A `flush` pulse invalidates every cache entry, so the next request for any page reads memory.
- R7: A `flush` during an outstanding table read still lets that translation complete normally, but its entry is not cached.
- R8: Fills replace entries in round-robin order over the eight slots. The ninth distinct fill after reset evicts the first page filled, and pages filled later stay cached.
- R9: `req_ready` is high only while no translation is in progress. `rsp_valid` with its payload, and `mem_req_valid` with its address, hold steady until their handshake completes.
- R10: After reset, `req_ready` = 1, `rsp_valid` = 0 and `mem_req_valid` = 0.
- R11: A write to `base_wdata` / `len_wdata` with its enable applies to every later request, so a new table at a new base with up to 64 entries is used after a switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_laddr | input | 16 | Logical address (page 15:10, offset 9:0) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_paddr | output | 16 | Physical address (frame 15:10, offset 9:0), 0 on fault |
| rsp_fault | output | 2 | 0 ok, 1 page beyond length, 2 page not present |
| mem_req_valid | output | 1 | Table-entry read request valid |
| mem_req_ready | input | 1 | Memory accepts read request |
| mem_req_addr | output | 16 | Byte address of table entry |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 16 | Table entry: bit 15 present, low bits frame |
| base_we | input | 1 | Write enable for table base |
| base_wdata | input | 16 | New table base byte address |
| len_we | input | 1 | Write enable for table length |
| len_wdata | input | 7 | New table length in entries (0..64) |
| flush | input | 1 | Invalidate all cached translations |

## Verification
The bench builds the block with its default parameters: eight cache slots, 6-bit frames, and 16-bit logical and memory addresses. With only eight slots, a run of nine distinct pages reaches the round-robin wraparound. The 7-bit length register reaches both the full 64-page table and a length one short of a cached page, which exercises fault precedence. Memory and consumer back-pressure follow fixed stall patterns. A held-off memory port creates a window in which `flush` lands during a table read.

// File: rtl/mmu_pkg.sv
`timescale 1ns/1ps
package mmu_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_LEN  = 2'd1,
    FLT_INV  = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_CHECK,
    W_MREQ,
    W_MWAIT,
    W_RESP
  } walk_st_e;
endpackage

// File: rtl/mmu_ctxregs.sv
`timescale 1ns/1ps
module mmu_ctxregs #(
  parameter int MA_W  = 16,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [MA_W-1:0]  base_wdata,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_wdata,
  output logic [MA_W-1:0]  base_q,
  output logic [LEN_W-1:0] len_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
    end else begin
      if (base_we) base_q <= base_wdata;
      if (len_we)  len_q  <= len_wdata;
    end
  end
endmodule

// File: rtl/mmu_tlb.sv
`timescale 1ns/1ps
module mmu_tlb #(
  parameter int N    = 8,
  parameter int PN_W = 6,
  parameter int FR_W = 6,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [PN_W-1:0] lk_page,
  input  logic            fill_en,
  input  logic [PN_W-1:0] fill_page,
  input  logic [FR_W-1:0] fill_frame,
  output logic [N-1:0]    hit_vec,
  output logic            hit,
  output logic [FR_W-1:0] hit_frame
);
  logic [N-1:0]    vld;
  logic [PN_W-1:0] tag [N];
  logic [FR_W-1:0] frm [N];
  logic [IW-1:0]   vic_q;

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[i] <= 1'b0;
        tag[i] <= '0;
        frm[i] <= '0;
      end else if (flush) begin
        vld[i] <= 1'b0;
      end else if (fill_en && vic_q == IW'(i)) begin
        vld[i] <= 1'b1;
        tag[i] <= fill_page;
        frm[i] <= fill_frame;
      end
    end
    assign hit_vec[i] = vld[i] && (tag[i] == lk_page);
  end

  always_comb begin
    hit_frame = '0;
    for (int k = 0; k < N; k++) begin
      if (hit_vec[k]) hit_frame = hit_frame | frm[k];
    end
  end
  assign hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vic_q <= '0;
    end else if (fill_en && !flush) begin
      vic_q <= (vic_q == IW'(N-1)) ? '0 : vic_q + IW'(1);
    end
  end
endmodule

// File: rtl/mmu_walk.sv
`timescale 1ns/1ps
module mmu_walk import mmu_pkg::*; #(
  parameter int LA_W      = 16,
  parameter int OFF_W     = 10,
  parameter int FR_W      = 6,
  parameter int MA_W      = 16,
  parameter int PTE_W     = 16,
  parameter int PTE_VBIT  = 15,
  parameter int PTE_BYTES = 2,
  localparam int PN_W   = LA_W - OFF_W,
  localparam int PA_W   = FR_W + OFF_W,
  localparam int LEN_W  = PN_W + 1,
  localparam int PTE_SH = $clog2(PTE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LA_W-1:0]  req_laddr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [MA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  input  logic [MA_W-1:0]  base_q,
  input  logic [LEN_W-1:0] len_q,
  input  logic             flush,
  input  logic             tlb_hit,
  input  logic [FR_W-1:0]  tlb_frame,
  output logic [PN_W-1:0]  lk_page,
  output logic             fill_en,
  output logic [PN_W-1:0]  fill_page,
  output logic [FR_W-1:0]  fill_frame
);
  walk_st_e         st;
  logic [PN_W-1:0]  page_q;
  logic [OFF_W-1:0] off_q;
  logic [MA_W-1:0]  addr_q;
  logic [PA_W-1:0]  paddr_q;
  fault_e           fault_q;
  logic             flushed_q;
  logic             len_fail;
  logic [MA_W-1:0]  ent_addr;
  logic             pte_present;
  logic             pte_unused;

  assign len_fail    = {1'b0, page_q} >= len_q;
  assign ent_addr    = base_q + (MA_W'(page_q) << PTE_SH);
  assign pte_present = mem_rsp_data[PTE_VBIT];
  assign pte_unused  = ^mem_rsp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= W_IDLE;
      page_q    <= '0;
      off_q     <= '0;
      addr_q    <= '0;
      paddr_q   <= '0;
      fault_q   <= FLT_NONE;
      flushed_q <= 1'b0;
    end else begin
      if (st != W_IDLE && flush) flushed_q <= 1'b1;
      case (st)
        W_IDLE: if (req_valid) begin
          page_q    <= req_laddr[LA_W-1:OFF_W];
          off_q     <= req_laddr[OFF_W-1:0];
          flushed_q <= 1'b0;
          st        <= W_CHECK;
        end
        W_CHECK: begin
          if (len_fail) begin
            fault_q <= FLT_LEN;
            paddr_q <= '0;
            st      <= W_RESP;
          end else if (tlb_hit) begin
            fault_q <= FLT_NONE;
            paddr_q <= {tlb_frame, off_q};
            st      <= W_RESP;
          end else begin
            addr_q <= ent_addr;
            st     <= W_MREQ;
          end
        end
        W_MREQ: if (mem_req_ready) st <= W_MWAIT;
        W_MWAIT: if (mem_rsp_valid) begin
          if (pte_present) begin
            fault_q <= FLT_NONE;
            paddr_q <= {mem_rsp_data[FR_W-1:0], off_q};
          end else begin
            fault_q <= FLT_INV;
            paddr_q <= '0;
          end
          st <= W_RESP;
        end
        W_RESP: if (rsp_ready) st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == W_IDLE);
  assign rsp_valid     = (st == W_RESP);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign mem_req_valid = (st == W_MREQ);
  assign mem_req_addr  = addr_q;
  assign lk_page       = page_q;
  assign fill_en       = (st == W_MWAIT) && mem_rsp_valid && pte_present
                         && !flushed_q && !flush;
  assign fill_page     = page_q;
  assign fill_frame    = mem_rsp_data[FR_W-1:0];
endmodule

// File: rtl/paging_mmu.sv
`timescale 1ns/1ps
module paging_mmu #(
  parameter int LA_W      = 16,
  parameter int OFF_W     = 10,
  parameter int FR_W      = 6,
  parameter int MA_W      = 16,
  parameter int PTE_W     = 16,
  parameter int PTE_VBIT  = 15,
  parameter int PTE_BYTES = 2,
  parameter int TLB_N     = 8,
  localparam int PN_W  = LA_W - OFF_W,
  localparam int PA_W  = FR_W + OFF_W,
  localparam int LEN_W = PN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LA_W-1:0]  req_laddr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [MA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  input  logic             base_we,
  input  logic [MA_W-1:0]  base_wdata,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_wdata,
  input  logic             flush
);
  logic [MA_W-1:0]  base_q;
  logic [LEN_W-1:0] len_q;
  logic [PN_W-1:0]  lk_page;
  logic [TLB_N-1:0] tlb_hitvec;
  logic             tlb_hit;
  logic [FR_W-1:0]  tlb_frame;
  logic             fill_en;
  logic [PN_W-1:0]  fill_page;
  logic [FR_W-1:0]  fill_frame;

  mmu_ctxregs #(.MA_W(MA_W), .LEN_W(LEN_W)) u_ctx (
    .clk(clk), .rst_n(rst_n),
    .base_we(base_we), .base_wdata(base_wdata),
    .len_we(len_we), .len_wdata(len_wdata),
    .base_q(base_q), .len_q(len_q)
  );

  mmu_tlb #(.N(TLB_N), .PN_W(PN_W), .FR_W(FR_W)) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_page(lk_page),
    .fill_en(fill_en), .fill_page(fill_page), .fill_frame(fill_frame),
    .hit_vec(tlb_hitvec), .hit(tlb_hit), .hit_frame(tlb_frame)
  );

  mmu_walk #(
    .LA_W(LA_W), .OFF_W(OFF_W), .FR_W(FR_W), .MA_W(MA_W),
    .PTE_W(PTE_W), .PTE_VBIT(PTE_VBIT), .PTE_BYTES(PTE_BYTES)
  ) u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .base_q(base_q), .len_q(len_q), .flush(flush),
    .tlb_hit(tlb_hit), .tlb_frame(tlb_frame), .lk_page(lk_page),
    .fill_en(fill_en), .fill_page(fill_page), .fill_frame(fill_frame)
  );
endmodule

// File: rtl/mmu_sva.sv
`timescale 1ns/1ps
module mmu_sva #(
  parameter int N     = 8,
  parameter int PN_W  = 6,
  parameter int PA_W  = 16,
  parameter int MA_W  = 16,
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [1:0]       rsp_fault,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [MA_W-1:0]  mem_req_addr,
  input logic             flush,
  input logic [N-1:0]     hit_vec,
  input logic [PN_W-1:0]  pg,
  input logic [LEN_W-1:0] len
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_req_valid); // R9
  AST_NO_DUP_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> hit_vec == '0); // R6
  AST_LEN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> {1'b0, $past(pg)} < $past(len)); // R4
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'd3); // R5
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'd0 |-> rsp_paddr == '0); // R4
endmodule

bind paging_mmu mmu_sva #(
  .N(TLB_N), .PN_W(PN_W), .PA_W(PA_W), .MA_W(MA_W), .LEN_W(LEN_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .flush(flush),
  .hit_vec(tlb_hitvec), .pg(lk_page), .len(len_q)
);

// File: tb/tb_paging_mmu.sv
`timescale 1ns/1ps
module tb_paging_mmu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_laddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        base_we = 1'b0;
  logic [15:0] base_wdata = '0;
  logic        len_we = 1'b0;
  logic [6:0]  len_wdata = '0;
  logic        flush = 1'b0;

  paging_mmu dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .base_we(base_we), .base_wdata(base_wdata),
    .len_we(len_we), .len_wdata(len_wdata), .flush(flush)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int reads = 0;
  int cyc = 0;
  bit stall = 1'b0;
  bit pend = 1'b0;
  logic [15:0] hold_addr = '0;
  logic [15:0] ptmem [256];
  logic [17:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int frame_a(input int p); return (p * 5 + 7) % 64; endfunction
  function automatic int frame_b(input int p); return (p * 3 + 1) % 64; endfunction

  // memory model and response monitor share one loop per cycle
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = ptmem[hold_addr[8:1]];
        pend = 1'b0;
      end
      mem_req_ready = !stall && (cyc % 4 != 2);
      if (mem_req_valid && mem_req_ready) begin
        pend = 1'b1;
        hold_addr = mem_req_addr;
        reads++;
      end
      rsp_ready = (cyc % 3 != 1);
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected response", int'({rsp_paddr, rsp_fault}), 0);
        end else begin
          logic [17:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rsp_paddr == e[17:2], {t, " paddr"}, int'(rsp_paddr), int'(e[17:2]));
          chk(rsp_fault == e[1:0], {t, " fault"}, int'(rsp_fault), int'(e[1:0]));
        end
      end
    end
  end

  task automatic xlate(input int page, input int off, input int frame, input int fault,
                       input int exp_rd, input string tag);
    int r0;
    logic [15:0] pa;
    r0 = reads;
    pa = (fault == 0) ? 16'((frame << 10) | off) : 16'h0;
    exp_q.push_back({pa, 2'(fault)});
    tag_q.push_back(tag);
    @(negedge clk);
    req_laddr = 16'((page << 10) | off);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 busy req_ready", int'(req_ready), 0);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(reads - r0 == exp_rd, {tag, " reads"}, reads - r0, exp_rd);
  endtask

  task automatic set_ctx(input int base, input int len);
    @(negedge clk);
    base_we = 1'b1; base_wdata = 16'(base);
    len_we = 1'b1;  len_wdata = 7'(len);
    @(negedge clk);
    base_we = 1'b0; len_we = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ptmem[i] = 16'h0;
    for (int p = 0; p < 16; p++)
      ptmem[32 + p] = (p == 5) ? 16'(frame_a(p)) : (16'h8000 | 16'(frame_a(p)));
    for (int p = 0; p < 64; p++) ptmem[128 + p] = 16'h8000 | 16'(frame_b(p));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 req_ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R10 rsp_valid", int'(rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R10 mem_req_valid", int'(mem_req_valid), 0);

    set_ctx(16'h0040, 16);
    xlate(3, 10'h123, frame_a(3), 0, 1, "R3 miss page3");
    xlate(3, 10'h3FF, frame_a(3), 0, 0, "R2 hit page3");
    xlate(20, 10'h001, 0, 1, 0, "R4 beyond length");
    xlate(16, 10'h000, 0, 1, 0, "R4 page equals length");
    xlate(15, 10'h000, frame_a(15), 0, 1, "R4 page length-1");
    xlate(5, 10'h055, 0, 2, 1, "R5 invalid entry");
    xlate(5, 10'h055, 0, 2, 1, "R5 invalid not cached");
    xlate(0, 10'h200, frame_a(0), 0, 1, "R1 fill page0");
    xlate(1, 10'h001, frame_a(1), 0, 1, "R1 fill page1");
    xlate(2, 10'h3C0, frame_a(2), 0, 1, "R8 fill page2");
    xlate(4, 10'h0F0, frame_a(4), 0, 1, "R8 fill page4");
    xlate(6, 10'h00F, frame_a(6), 0, 1, "R8 fill page6");
    xlate(7, 10'h2AA, frame_a(7), 0, 1, "R8 fill page7");
    xlate(8, 10'h155, frame_a(8), 0, 1, "R8 ninth fill");
    xlate(15, 10'h010, frame_a(15), 0, 0, "R8 second fill kept");
    xlate(3, 10'h020, frame_a(3), 0, 1, "R8 first fill evicted");
    xlate(15, 10'h030, frame_a(15), 0, 1, "R8 next victim");
    xlate(1, 10'h040, frame_a(1), 0, 0, "R8 later fill kept");

    set_ctx(16'h0040, 15);
    xlate(15, 10'h030, 0, 1, 0, "R4 length beats hit");
    set_ctx(16'h0040, 16);

    pulse_flush();
    xlate(1, 10'h040, frame_a(1), 0, 1, "R6 flush clears");

    stall = 1'b1;
    fork
      xlate(9, 10'h0AB, frame_a(9), 0, 1, "R7 flush during walk");
      begin
        while (!mem_req_valid) @(negedge clk);
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        stall = 1'b0;
      end
    join
    xlate(9, 10'h0AB, frame_a(9), 0, 1, "R7 not installed");

    set_ctx(16'h0100, 64);
    pulse_flush();
    xlate(63, 10'h2AA, frame_b(63), 0, 1, "R11 new base page63");
    xlate(0, 10'h001, frame_b(0), 0, 1, "R11 new table page0");
    xlate(0, 10'h3FE, frame_b(0), 0, 0, "R2 hit after switch");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule